// File: doc/BRIEF.md
# One-Wire ROM Identity Reader

This block drives a byte-level single-wire bus master to fetch the 64-bit identity of a single slave device. A one-cycle `start` launches a fixed sequence: a bus reset with presence sampling, then the read-identity command byte, then eight byte reads. The first byte read is the device family code. The next six bytes form the 48-bit serial number. The eighth byte is a check byte that the block verifies against a CRC-8 it computes over the first seven bytes.

The master is reached through a request/response handshake. The sequencer raises `owReq` for one cycle with an operation code and, for writes, a data byte. The master answers with a one-cycle `owDone` that carries the read byte and the presence result. After the last byte the block pulses `done`. The decoded fields and the flags for presence, family match, CRC match and overall validity then stay fixed until the next start.

Top module: `romid_fetch`

## Requirements
- R1: A `start` seen while idle makes the first request appear the next cycle, with `owOp` = 2'b00 (bus reset). The operation codes are 2'b00 reset, 2'b01 write byte and 2'b10 read byte. A `start` seen while busy has no effect on the sequence or its results.
- R2: `presenceOk` takes the value of `owPresence` sampled with the `owDone` that answers the reset request. `owPresence` in later responses is ignored.
- R3: The second request is a write (`owOp` = 2'b01) with `owWrData` = 8'h33.
- R4: Each request is a single-cycle `owReq`. The next request follows in the cycle after the `owDone` that answers the previous one, and nothing is requested in between. Exactly eight read requests (`owOp` = 2'b10) follow the write.
- R5: The first byte read appears on `familyCode`. `familyOk` is 1 exactly when that byte equals 8'h01. A mismatch does not shorten the sequence.
- R6: Read bytes two to seven form `serialNum`, with the first of them in bits 7:0 and each later one in the next higher byte.
- R7: `crcOk` is 1 when the eighth byte read equals the CRC-8 of the first seven bytes. The CRC uses polynomial x^8+x^5+x^4+1, initial value 0, and takes each byte least significant bit first.
- R8: `idValid` is `presenceOk` AND `crcOk`. Without presence the full ten-request sequence still runs and `idValid` ends at 0.
- R9: `done` is high for exactly one cycle, the cycle after the `owDone` for the eighth byte. `busy` is low in that same cycle.
- R10: A start clears all result outputs to 0 in the cycle after it is seen. While idle, results hold their values even if `owDone` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch one identity fetch |
| owReq | output | 1 | One-cycle request to the bus master |
| owOp | output | 2 | Request kind: 00 reset, 01 write, 10 read |
| owWrData | output | 8 | Byte to write for a write request |
| owDone | input | 1 | One-cycle completion from the bus master |
| owRdData | input | 8 | Byte returned with a read completion |
| owPresence | input | 1 | Presence result returned with a reset completion |
| familyCode | output | 8 | First identity byte |
| serialNum | output | 48 | Six serial bytes, first received in the low byte |
| presenceOk | output | 1 | Device answered the reset |
| familyOk | output | 1 | Family code equals the expected value |
| crcOk | output | 1 | Check byte matches the computed CRC |
| idValid | output | 1 | Presence and CRC both good |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest case to reach from the ports is a second `start` that lands while a read is outstanding. It should be ignored, but if it were taken it would wipe results already captured. The bench's master model raises `start` inside a response wait part-way through the byte reads. It then checks that the family code captured earlier survives and that exactly ten requests are seen. The same model drives a different presence value in every response except the one for the reset, so a block that latches presence at the wrong time gives a wrong flag. Response latency is swept from one to three cycles across many identity patterns, and the known-good check byte of a published example ROM is included.

// File: rtl/romid_pkg.sv
package romid_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } owOp_e;

  typedef struct packed {
    logic clearAll;
    logic latchPres;
    logic capture;
  } seqStrobe_t;

  // Reflected CRC-8, polynomial x^8+x^5+x^4+1, data taken LSB first
  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] c;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ dataIn[b]) c = (c >> 1) ^ 8'h8C;
      else                  c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/romid_ctrl.sv
module romid_ctrl
  import romid_pkg::*;
#(
  parameter int          ID_BYTES = 8,
  parameter logic [7:0]  READ_CMD = 8'h33,
  localparam int         IDX_W    = $clog2(ID_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             owDone,
  output logic             owReq,
  output logic [1:0]       owOp,
  output logic [7:0]       owWrData,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] byteIdx,
  output logic             busy,
  output logic             done
);

  localparam int STEP_W = $clog2(ID_BYTES + 2);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ID_BYTES + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e            state;
  logic [STEP_W-1:0] step;
  logic              respGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          step  <= '0;
          state <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (owDone) begin
          if (step == LAST_STEP) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            step  <= step + 1'b1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    respGo           = (state == S_WAIT) && owDone;
    strobe.clearAll  = (state == S_IDLE) && start;
    strobe.latchPres = respGo && (step == '0);
    strobe.capture   = respGo && (step >= STEP_W'(2));
    byteIdx          = IDX_W'(step - STEP_W'(2));
    owReq            = (state == S_ISSUE);
    busy             = (state != S_IDLE);
    if (step == '0) begin
      owOp     = OP_RESET;
      owWrData = 8'h00;
    end else if (step == STEP_W'(1)) begin
      owOp     = OP_WRITE;
      owWrData = READ_CMD;
    end else begin
      owOp     = OP_READ;
      owWrData = 8'h00;
    end
  end

endmodule

// File: rtl/romid_data.sv
module romid_data
  import romid_pkg::*;
#(
  parameter int          ID_BYTES    = 8,
  parameter logic [7:0]  FAMILY_CODE = 8'h01,
  localparam int         IDX_W       = $clog2(ID_BYTES),
  localparam int         SERIAL_W    = 8 * (ID_BYTES - 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [IDX_W-1:0]    byteIdx,
  input  logic [7:0]          owRdData,
  input  logic                owPresence,
  output logic [7:0]          familyCode,
  output logic [SERIAL_W-1:0] serialNum,
  output logic                presenceOk,
  output logic                familyOk,
  output logic                crcOk,
  output logic                idValid
);

  localparam int SERIAL_BYTES = ID_BYTES - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES - 1);

  logic [7:0] crcAcc;
  logic [7:0] crcNext;
  logic       isLast;
  logic       crcMatch;

  always_comb begin
    crcNext  = crc8Step(crcAcc, owRdData);
    isLast   = (byteIdx == LAST_IDX);
    crcMatch = (crcAcc == owRdData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presenceOk <= 1'b0;
    end else if (strobe.clearAll) begin
      presenceOk <= 1'b0;
    end else if (strobe.latchPres) begin
      presenceOk <= owPresence;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      familyCode <= '0;
      familyOk   <= 1'b0;
    end else if (strobe.clearAll) begin
      familyCode <= '0;
      familyOk   <= 1'b0;
    end else if (strobe.capture && byteIdx == '0) begin
      familyCode <= owRdData;
      familyOk   <= (owRdData == FAMILY_CODE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc <= '0;
    end else if (strobe.clearAll) begin
      crcAcc <= '0;
    end else if (strobe.capture && !isLast) begin
      crcAcc <= crcNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcOk   <= 1'b0;
      idValid <= 1'b0;
    end else if (strobe.clearAll) begin
      crcOk   <= 1'b0;
      idValid <= 1'b0;
    end else if (strobe.capture && isLast) begin
      crcOk   <= crcMatch;
      idValid <= presenceOk && crcMatch;
    end
  end

  for (genvar lane = 0; lane < SERIAL_BYTES; lane++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(lane + 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        serialNum[lane*8 +: 8] <= '0;
      end else if (strobe.clearAll) begin
        serialNum[lane*8 +: 8] <= '0;
      end else if (strobe.capture && byteIdx == LANE_IDX) begin
        serialNum[lane*8 +: 8] <= owRdData;
      end
    end
  end

endmodule

// File: rtl/romid_fetch.sv
module romid_fetch
  import romid_pkg::*;
#(
  parameter int         ID_BYTES    = 8,
  parameter logic [7:0] FAMILY_CODE = 8'h01,
  parameter logic [7:0] READ_CMD    = 8'h33
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  output logic                      owReq,
  output logic [1:0]                owOp,
  output logic [7:0]                owWrData,
  input  logic                      owDone,
  input  logic [7:0]                owRdData,
  input  logic                      owPresence,
  output logic [7:0]                familyCode,
  output logic [8*(ID_BYTES-2)-1:0] serialNum,
  output logic                      presenceOk,
  output logic                      familyOk,
  output logic                      crcOk,
  output logic                      idValid,
  output logic                      busy,
  output logic                      done
);

  localparam int IDX_W = $clog2(ID_BYTES);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] byteIdx;

  romid_ctrl #(
    .ID_BYTES(ID_BYTES),
    .READ_CMD(READ_CMD)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .owDone  (owDone),
    .owReq   (owReq),
    .owOp    (owOp),
    .owWrData(owWrData),
    .strobe  (strobe),
    .byteIdx (byteIdx),
    .busy    (busy),
    .done    (done)
  );

  romid_data #(
    .ID_BYTES   (ID_BYTES),
    .FAMILY_CODE(FAMILY_CODE)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteIdx   (byteIdx),
    .owRdData  (owRdData),
    .owPresence(owPresence),
    .familyCode(familyCode),
    .serialNum (serialNum),
    .presenceOk(presenceOk),
    .familyOk  (familyOk),
    .crcOk     (crcOk),
    .idValid   (idValid)
  );

endmodule

// File: rtl/romid_fetch_chk.sv
module romid_fetch_chk #(
  parameter logic [7:0] READ_CMD = 8'h33,
  parameter int         SERIAL_W = 48
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                owReq,
  input logic [1:0]          owOp,
  input logic [7:0]          owWrData,
  input logic                busy,
  input logic                done,
  input logic                presenceOk,
  input logic                crcOk,
  input logic                idValid,
  input logic [7:0]          familyCode,
  input logic [SERIAL_W-1:0] serialNum
);

  p_first_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (owReq && owOp == 2'b00));

  p_write_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (owReq && owOp == 2'b01) |-> (owWrData == READ_CMD));

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    owReq |=> !owReq);

  p_req_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    owReq |-> busy);

  p_valid_needs_both_r8: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> (presenceOk && crcOk));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(serialNum) && $stable(familyCode) &&
                           $stable(idValid) && $stable(crcOk) && $stable(presenceOk)));

endmodule

bind romid_fetch romid_fetch_chk #(
  .READ_CMD(READ_CMD),
  .SERIAL_W(8 * (ID_BYTES - 2))
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .owReq     (owReq),
  .owOp      (owOp),
  .owWrData  (owWrData),
  .busy      (busy),
  .done      (done),
  .presenceOk(presenceOk),
  .crcOk     (crcOk),
  .idValid   (idValid),
  .familyCode(familyCode),
  .serialNum (serialNum)
);

// File: tb/test_romid_fetch.sv
module test_romid_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        owReq;
  logic [1:0]  owOp;
  logic [7:0]  owWrData;
  logic        owDone = 1'b0;
  logic [7:0]  owRdData = 8'h00;
  logic        owPresence = 1'b0;
  logic [7:0]  familyCode;
  logic [47:0] serialNum;
  logic        presenceOk, familyOk, crcOk, idValid, busy, done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  romid_fetch i_romid_fetch (
    .clk(clk), .rstN(rstN), .start(start),
    .owReq(owReq), .owOp(owOp), .owWrData(owWrData),
    .owDone(owDone), .owRdData(owRdData), .owPresence(owPresence),
    .familyCode(familyCode), .serialNum(serialNum),
    .presenceOk(presenceOk), .familyOk(familyOk), .crcOk(crcOk),
    .idValid(idValid), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bytewise formulation: fold the byte in, then eight reflected shifts
  function automatic logic [7:0] refCrc(input logic [63:0] id);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 7; i++) begin
      c = c ^ id[i*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return c;
  endfunction

  task automatic runSeq(input logic [63:0] id, input bit pres, input int lat, input bit poke);
    logic [47:0] expSer;
    bit          goodCrc;
    for (int i = 0; i < 6; i++) expSer[i*8 +: 8] = id[(i+1)*8 +: 8];
    goodCrc = (refCrc(id) == id[63:56]);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
    check(serialNum == 48'd0 && familyCode == 8'd0 && !idValid && !crcOk && !presenceOk && !familyOk,
          "R10", "results cleared by start", 64'(serialNum), 64'd0);

    for (int cmd = 0; cmd < 10; cmd++) begin
      logic [1:0] expOp;
      int n = 0;
      while (!owReq && n < 40) begin @(negedge clk); n++; end
      expOp = (cmd == 0) ? 2'b00 : (cmd == 1) ? 2'b01 : 2'b10;
      check(owReq && n == 0, (cmd == 0) ? "R1" : "R4", "request issued promptly", 64'(n), 64'd0);
      check(owOp == expOp, (cmd == 0) ? "R1" : (cmd == 1) ? "R3" : "R4", "request kind", 64'(owOp), 64'(expOp));
      if (cmd == 1) check(owWrData == 8'h33, "R3", "command byte", 64'(owWrData), 64'h33);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        start = (poke && cmd == 5 && k == 0);
        check(!owReq, "R4", "no request while waiting", 64'(owReq), 64'd0);
      end
      start      = 1'b0;
      owDone     = 1'b1;
      owRdData   = (cmd >= 2) ? id[(cmd-2)*8 +: 8] : 8'h5A;
      owPresence = (cmd == 0) ? pres : !pres;
      @(negedge clk);
      owDone = 1'b0;
      owRdData = 8'h00;
      if (cmd < 9)
        check(busy && !done, "R9", "no early completion", 64'(done), 64'd0);
    end

    check(done && !busy, "R9", "done pulse at end", 64'({done, busy}), 64'b10);
    check(presenceOk == pres, "R2", "presence flag", 64'(presenceOk), 64'(pres));
    check(familyCode == id[7:0], "R5", "family code", 64'(familyCode), 64'(id[7:0]));
    check(familyOk == (id[7:0] == 8'h01), "R5", "family match", 64'(familyOk), 64'(id[7:0] == 8'h01));
    check(serialNum == expSer, "R6", "serial number", 64'(serialNum), 64'(expSer));
    check(crcOk == goodCrc, "R7", "crc flag", 64'(crcOk), 64'(goodCrc));
    check(idValid == (pres && goodCrc), "R8", "valid flag", 64'(idValid), 64'(pres && goodCrc));
    @(negedge clk);
    check(!done, "R9", "done single cycle", 64'(done), 64'd0);

    owDone = 1'b1; owRdData = 8'hC3; owPresence = !pres;
    @(negedge clk);
    owDone = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !owReq, "R10", "idle response ignored", 64'({busy, owReq}), 64'd0);
    check(serialNum == expSer && familyCode == id[7:0] && presenceOk == pres,
          "R10", "results held while idle", 64'(serialNum), 64'(expSer));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R4 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!owReq && !busy && !done && serialNum == 48'd0 && !idValid,
          "R10", "reset state", 64'({owReq, busy, done, idValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runSeq(64'h0, 1'b1, 1, 1'b0);                       // all zero id: check byte 0 is correct
    runSeq(64'hA2000000_01B81C02, 1'b1, 2, 1'b0);       // published example with known check byte
    runSeq(64'hFFFFFFFF_FFFFFFFF, 1'b0, 1, 1'b0);       // absent device, bus reads high

    for (int seed = 0; seed < 12; seed++) begin
      logic [63:0] id;
      for (int i = 0; i < 7; i++) id[i*8 +: 8] = 8'(seed * 29 + i * 53 + 7);
      if (seed % 3 == 0) id[7:0] = 8'h01;
      id[63:56] = (seed % 4 == 3) ? (refCrc(id) ^ 8'h10) : refCrc(id);
      runSeq(id, (seed % 5) != 4, 1 + seed % 3, seed == 6 || seed == 7);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule